// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

The unit sits between one 32-bit bus master and a synchronous, byte-addressable word memory. Ordinary accesses that fall inside the target region go straight to the memory. Accesses that fall inside a larger alias window are turned into single-bit operations on the target region. Each word in the alias window stands for one bit of one byte in the target region.

An alias read returns the selected bit, zero-extended to a full word. An alias write changes only the selected bit. It does this with an internal read-modify-write: the memory word is read in one cycle and the merged byte is written back in the next. The master sees a valid/ready request channel and a one-beat response.

Only requests flagged as coming from the CPU master are translated. Any other address, including an alias address from another master, gets an error response and leaves memory untouched.

Top module: `bitband_unit`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_en` are 0.
- R2: A read inside the target window is answered one cycle after acceptance. The response carries the memory word, little endian: lane k, bits 8k+7..8k, holds the byte at word address + k.
- R3: A write inside the target window updates exactly the byte lanes whose `req_wstrb` bit is set. It is answered one cycle after acceptance, with `rsp_err`=0.
- R4: A CPU alias read of address `ALIAS_BASE + byte_offset*32 + bit*4` (bit 0..7) returns 32'h1 when that bit of target byte `byte_offset` is set, and 32'h0 when it is clear. It is answered one cycle after acceptance.
- R5: A CPU alias write sets the selected bit to `req_wdata[0]` and leaves every other bit of memory unchanged. Bits 31..1 of the write data have no effect.
- R6: An alias write reads memory in the cycle of acceptance and writes back in the next cycle. `req_ready` stays 0 until the response cycle has passed, so no other request is accepted in between. The response comes two cycles after acceptance.
- R7: With `TGT_BASE`=0x2000_0000 and `ALIAS_BASE`=0x2200_0000, alias address 0x2200_6008 selects bit 2 of the byte at 0x2000_0300.
- R8: An alias access with `req_cpu`=0 gets `rsp_err`=1 one cycle after acceptance. It performs no memory access.
- R9: An access outside both windows gets `rsp_err`=1 and `rsp_rdata`=0 one cycle after acceptance. It performs no memory access.
- R10: Every accepted request produces exactly one response beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 1 | Request issued by the CPU master |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte-lane enables for plain writes |
| rsp_valid | output | 1 | Response beat |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Word index into the target region |
| mem_wstrb | output | 4 | Memory byte-lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after `mem_en` |

## Verification
Two functions can fall in the same cycle: the write-back of an alias write, and the next request that the master keeps waiting on the bus. The bench provokes this by presenting a plain write to the same word right after the alias write is accepted, and holding it through the busy cycles. Each cycle it checks that `req_ready` stays low until the alias response has passed. It then checks that the final memory contents equal the model, with the bit update applied before the plain write.

// File: rtl/bitband_unit.sv
module bitband_unit #(
  parameter logic [31:0] TGT_BASE   = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          TGT_BYTES  = 32768,
  localparam int         AW         = $clog2(TGT_BYTES / 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_cpu,
  input  logic [31:0]   req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [3:0]    req_wstrb,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_wstrb,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);

  localparam logic [31:0] TSPAN = 32'(TGT_BYTES);
  localparam logic [31:0] ASPAN = 32'(TGT_BYTES) << 5;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_RESP} st_t;
  typedef enum logic [2:0] {K_PRD, K_PWR, K_BRD, K_BWR, K_ERR} kind_t;

  st_t          state;
  kind_t        kind_q, kind_d;
  logic [1:0]   lane_q;
  logic [2:0]   bit_q;
  logic [AW-1:0] word_q;
  logic         val_q;

  logic [31:0] tgt_off, al_off;
  logic        in_tgt, in_alias, is_bit, legal, acc;
  logic [7:0]  old_byte, new_byte;

  assign tgt_off  = req_addr - TGT_BASE;
  assign al_off   = req_addr - ALIAS_BASE;
  assign in_tgt   = tgt_off < TSPAN;
  assign in_alias = al_off < ASPAN;
  assign is_bit   = in_alias && req_cpu && !in_tgt;
  assign legal    = in_tgt || is_bit;

  assign req_ready = (state == ST_IDLE);
  assign acc       = req_valid && req_ready;

  always_comb begin
    if (!legal)          kind_d = K_ERR;
    else if (in_tgt)     kind_d = req_write ? K_PWR : K_PRD;
    else                 kind_d = req_write ? K_BWR : K_BRD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind_q <= K_ERR;
      lane_q <= '0;
      bit_q  <= '0;
      word_q <= '0;
      val_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (acc) begin
          kind_q <= kind_d;
          lane_q <= al_off[6:5];
          bit_q  <= al_off[4:2];
          word_q <= al_off[AW+6:7];
          val_q  <= req_wdata[0];
          state  <= (kind_d == K_BWR) ? ST_WB : ST_RESP;
        end
        ST_WB:   state <= ST_RESP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign old_byte = mem_rdata[lane_q*8 +: 8];

  always_comb begin
    new_byte         = old_byte;
    new_byte[bit_q]  = val_q;
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = in_tgt ? tgt_off[AW+1:2] : al_off[AW+6:7];
    mem_wstrb = 4'b0000;
    mem_wdata = req_wdata;
    if (state == ST_WB) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = word_q;
      mem_wstrb = 4'b0001 << lane_q;
      mem_wdata = {4{new_byte}};
    end else if (acc && legal) begin
      mem_en = 1'b1;
      if (kind_d == K_PWR) begin
        mem_we    = 1'b1;
        mem_wstrb = req_wstrb;
      end
    end
  end

  assign rsp_valid = (state == ST_RESP);
  assign rsp_err   = rsp_valid && (kind_q == K_ERR);

  always_comb begin
    rsp_rdata = '0;
    if (rsp_valid && kind_q == K_PRD) rsp_rdata = mem_rdata;
    if (rsp_valid && kind_q == K_BRD) rsp_rdata = {31'b0, mem_rdata[{lane_q, bit_q}]};
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_ready && !rsp_valid));

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  assert_writeback_single_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB) |-> ($countones(mem_wstrb) == 1 &&
      $countones(mem_wdata[lane_q*8 +: 8] ^ old_byte) <= 1));

  assert_bitwrite_holds_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && kind_d == K_BWR) |=> (!req_ready && mem_en && mem_we));

  assert_bitwrite_no_early_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && kind_d == K_BWR) |=> !rsp_valid);

  assert_illegal_no_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !legal) |-> !mem_en);

  assert_illegal_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !legal) |=> (rsp_valid && rsp_err && rsp_rdata == 32'h0));

  assert_single_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/tb_bitband_unit.sv
module tb_bitband_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES = 1024;
  localparam int NWORDS = NBYTES / 4;
  localparam int AW = $clog2(NWORDS);
  localparam logic [31:0] TB = 32'h2000_0000;
  localparam logic [31:0] AB = 32'h2200_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_cpu = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_wstrb = '0;
  logic req_ready, rsp_valid, rsp_err, mem_en, mem_we;
  logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_wstrb;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] ram [NWORDS];
  logic [7:0]  ref_mem [NBYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_unit #(.TGT_BASE(TB), .ALIAS_BASE(AB), .TGT_BYTES(NBYTES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cpu(req_cpu), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wstrb(req_wstrb), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 5);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++)
        ram[i] <= {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (mem_wstrb[k]) ram[mem_addr][k*8 +: 8] <= mem_wdata[k*8 +: 8];
      mem_rdata <= ram[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] aaddr(int byte_off, int bitn);
    return AB + 32'(byte_off * 32 + bitn * 4);
  endfunction

  task automatic model(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                       input logic [3:0] st, input logic cpu,
                       output int lat, output logic er, output logic [31:0] rd);
    longint toff, aoff;
    toff = longint'(a) - longint'(TB);
    aoff = longint'(a) - longint'(AB);
    lat = 1; er = 1'b0; rd = '0;
    if (toff >= 0 && toff < NBYTES) begin
      int w;
      w = int'(toff) / 4;
      if (wr) begin
        for (int k = 0; k < 4; k++) if (st[k]) ref_mem[w*4+k] = wd[k*8 +: 8];
      end else
        rd = {ref_mem[w*4+3], ref_mem[w*4+2], ref_mem[w*4+1], ref_mem[w*4]};
    end else if (aoff >= 0 && aoff < NBYTES * 32 && cpu) begin
      int b, n;
      b = int'(aoff) / 32;
      n = (int'(aoff) / 4) % 8;
      if (wr) begin
        lat = 2;
        ref_mem[b][n] = wd[0];
      end else
        rd = {31'b0, ref_mem[b][n]};
    end else
      er = 1'b1;
  endtask

  task automatic expect_rsp(input int lat, input logic er, input logic [31:0] rd, input string tag);
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, {tag, " R6 ready low while busy"}, 32'(req_ready), 0);
      chk(rsp_valid == (k == lat), {tag, " R10 response timing"}, 32'(rsp_valid), 32'(k == lat));
      if (k == lat) begin
        chk(rsp_err == er, {tag, " error flag"}, 32'(rsp_err), 32'(er));
        chk(rsp_rdata == rd, {tag, " read data"}, rsp_rdata, rd);
      end
    end
  endtask

  task automatic chk_mem(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < NBYTES; i++)
      if (ram[i/4][(i%4)*8 +: 8] !== ref_mem[i]) bad++;
    chk(bad == 0, {tag, " memory contents"}, 32'(bad), 0);
  endtask

  task automatic drive(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                       input logic [3:0] st, input logic cpu);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    req_wstrb = st; req_cpu = cpu;
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] st, input logic cpu, input string tag);
    int lat; logic er; logic [31:0] rd;
    @(negedge clk);
    drive(wr, a, wd, st, cpu);
    chk(req_ready == 1'b1, {tag, " ready when idle"}, 32'(req_ready), 1);
    model(wr, a, wd, st, cpu, lat, er, rd);
    @(posedge clk);
    #1 req_valid = 1'b0;
    expect_rsp(lat, er, rd, tag);
    chk_mem(tag);
  endtask

  initial begin
    for (int i = 0; i < NBYTES; i++) ref_mem[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_en == 1'b0, "R1 idle after reset",
        {29'b0, req_ready, rsp_valid, mem_en}, 32'h4);

    access(0, TB + 32'h0, 0, 0, 1, "R2 plain read first word");
    access(0, TB + 32'h3FC, 0, 0, 1, "R2 plain read last word");
    access(0, TB + 32'h124, 0, 0, 0, "R2 plain read from other master");
    access(1, TB + 32'h40, 32'hA1B2_C3D4, 4'b0101, 1, "R3 plain write lanes 0,2");
    access(0, TB + 32'h40, 0, 0, 1, "R3 read back partial write");
    access(1, TB + 32'h44, 32'h0102_0304, 4'b1111, 0, "R3 plain write full word");

    access(0, aaddr(0, 0), 0, 0, 1, "R4 alias read byte 0 bit 0");
    access(0, aaddr(0, 7), 0, 0, 1, "R4 alias read byte 0 bit 7");
    access(0, aaddr(NBYTES-1, 0), 0, 0, 1, "R4 alias read last byte bit 0");
    access(0, aaddr(NBYTES-1, 7), 0, 0, 1, "R4 alias read last byte bit 7");

    access(1, aaddr(0, 0), 32'hFFFF_FFFE, 0, 1, "R5 alias clear bit 0, upper data ignored");
    access(1, aaddr(0, 7), 32'h0000_0001, 0, 1, "R5 alias set byte 0 bit 7");
    access(1, aaddr(NBYTES-1, 0), 32'h8000_0001, 0, 1, "R5 alias set last byte bit 0");
    access(1, aaddr(NBYTES-1, 7), 32'h7FFF_FFFE, 0, 1, "R5 alias clear last byte bit 7");
    access(0, aaddr(NBYTES-1, 7), 0, 0, 1, "R5 alias read back last byte bit 7");

    access(1, 32'h2200_6008, 32'h1, 0, 1, "R7 example alias write");
    access(0, 32'h2000_0300, 0, 0, 1, "R7 example byte read back");
    access(1, 32'h2200_6008, 32'h0, 0, 1, "R7 example alias clear");
    access(0, 32'h2200_6008, 0, 0, 1, "R7 example alias read");

    access(1, aaddr(5, 3), 32'h1, 0, 0, "R8 alias write from other master");
    access(0, aaddr(5, 3), 0, 0, 0, "R8 alias read from other master");
    access(1, TB + 32'h400, 32'hFFFF_FFFF, 4'hF, 1, "R9 write past target end");
    access(0, 32'h1FFF_FFFC, 0, 0, 1, "R9 read below target");
    access(1, AB + 32'(NBYTES*32), 32'h1, 0, 1, "R9 write past alias end");

    begin
      int lat; logic er; logic [31:0] rd;
      @(negedge clk);
      drive(1, aaddr(8, 6), 32'h1, 0, 1);
      model(1, aaddr(8, 6), 32'h1, 0, 1, lat, er, rd);
      @(posedge clk);
      #1 drive(1, TB + 32'h8, 32'h5500_00AA, 4'b0001, 1);
      expect_rsp(lat, er, rd, "R6 alias write with rival queued");
      @(negedge clk);
      chk(req_ready == 1'b1, "R6 rival accepted after response", 32'(req_ready), 1);
      model(1, TB + 32'h8, 32'h5500_00AA, 4'b0001, 1, lat, er, rd);
      @(posedge clk);
      #1 req_valid = 1'b0;
      expect_rsp(lat, er, rd, "R6 rival plain write");
      chk_mem("R6 ordering of alias and rival");
    end

    for (int it = 0; it < 150; it++) begin
      int r;
      r = int'($urandom % 6);
      case (r)
        0: access(0, TB + 32'(($urandom % NWORDS) * 4), 0, 0, 1, "R2 mixed plain read");
        1: access(1, TB + 32'(($urandom % NWORDS) * 4), $urandom, 4'($urandom), 1, "R3 mixed plain write");
        2: access(0, aaddr(int'($urandom % NBYTES), int'($urandom % 8)), 0, 0, 1, "R4 mixed alias read");
        3: access(1, aaddr(int'($urandom % NBYTES), int'($urandom % 8)), $urandom, 0, 1, "R5 mixed alias write");
        4: access(1, aaddr(int'($urandom % NBYTES), int'($urandom % 8)), $urandom, 0, 0, "R8 mixed foreign alias");
        default: access(1, 32'h3000_0000 + 32'($urandom % 4096) * 4, $urandom, 4'hF, 1, "R9 mixed outside");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule